// File: doc/BRIEF.md
# Lockable Watchdog Timer with Pre-Timeout Warning

This peripheral guards a system against software hangs. A 32-bit counter, stepped by a slow tick, counts down from a programmed start value. When the remaining count equals a separate warning threshold, a pre-timeout interrupt flag is raised. When the count reaches zero, an expiry flag is raised, and a reset request can be driven to the system's reset logic. Software keeps the system alive by rewriting a start-value register before expiry. Each rewrite triggers a reload that takes three slow ticks, and a busy flag in the status word covers it.

A small register bus carries 16-bit data. Each 32-bit quantity (start value, warning threshold, live count) is split across a pair of 16-bit registers. A key register protects all other writable registers: writes reach them only after the key value 0xE551 has been written to it. The slow tick comes from an internal divide-by-`TICK_DIV` generator that stands in for a 32.768 kHz domain, so 32768 ticks make one second of timeout.

The sequencing core is a four-state machine:
- HALT: counter held.
- XFER: reload in progress, busy.
- RUN: counting down.
- FIRED: count at zero, expiry flagged.

Its transitions:
- HALT→RUN when the counter enable is set.
- RUN→HALT and FIRED→HALT when the enable is cleared.
- RUN→FIRED on the tick that brings the count to zero.
- Any state→XFER on a write to a start or threshold register.
- XFER→RUN or XFER→HALT on the third tick, depending on the enable, with the count loaded at that edge.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the following all read 0: control, mask, start value, threshold, count and status. The block is locked. `irq_o` and `rst_req_o` are low.
- R2: A write of 0xE551 to the key register (offset 0x20) unlocks the block. A write of any other value to it locks the block. While the block is locked, writes to every other register leave it unchanged and start no reload.
- R3: Each 32-bit value uses two registers: the upper register holds bits 31:16 and the lower register holds bits 15:0. The pairs are start value 0x04/0x00, threshold 0x30/0x2C and count readback 0x1C/0x18.
- R4: An accepted write to any of the four start or threshold registers sets status bit 4 (busy) from the next cycle. Busy stays set until the third tick after the write, between 2·TICK_DIV+1 and 3·TICK_DIV cycles. At that point the count equals the start value. A new such write restarts the reload, and this is the keep-alive.
- R5: With control bit 1 (count enable) set, the count falls by one per tick, and one tick occurs every TICK_DIV cycles. The count stays frozen while bit 1 is clear or a reload is in progress.
- R6: Status bit 0 is set on the tick where the count becomes equal to the threshold. `irq_o` is status bit 0 AND control bit 0 AND NOT mask-register (offset 0x14) bit 0.
- R7: Status bit 3 is set on the tick where the count reaches zero, and the count then stays at zero. `rst_req_o` is status bit 3 AND control bit 3. A threshold of zero sets status bits 0 and 3 together.
- R8: Writing the clear register (offset 0x0C) with bit 0 set clears status bit 0. Writing it with bit 3 set clears status bit 3. The other flag is unaffected.
- R9: Writing control (offset 0x08) with 0 freezes the count and drops `irq_o` and `rst_req_o` at once, with no effect on the status flags. Control bit 2 is stored and read back and has no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | HALF_W (16) | Write data |
| bus_rdata | output | HALF_W (16) | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Pre-timeout interrupt |
| rst_req_o | output | 1 | Expiry reset request |

## Verification
- **Register writes:** the bench applies each write at one rising edge. It reads back at the falling edge straight after, because control, mask, clear and the outputs derived from them change at that edge.
- **Busy period:** the bench measures the busy period in whole cycles from the write and checks it against the three-tick window of R4.
- **Pre-timeout and expiry:** the bench records the cycle of each flag's first appearance. The expected interval is (start − threshold) ticks after the enable write, with one tick of slack for the free-running tick phase and for the HALT→RUN step.
- **Count at each event:** the bench reads the count at the falling edge where the flag first shows. The next step is TICK_DIV cycles away, so the count must be exactly the threshold or zero.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 6;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_LDLO  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LDHI  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ICLR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CNTLO = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CNTHI = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_PRLO  = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_PRHI  = 6'h30;

    // control bit positions
    localparam int CB_IE = 0;
    localparam int CB_CE = 1;
    localparam int CB_NV = 2;
    localparam int CB_RE = 3;
    localparam int CTRL_W = 4;

    // status / clear bit positions
    localparam int SB_INT  = 0;
    localparam int SB_RST  = 3;
    localparam int SB_BUSY = 4;

    typedef enum logic [1:0] {
        WD_HALT  = 2'd0,
        WD_XFER  = 2'd1,
        WD_RUN   = 2'd2,
        WD_FIRED = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdg_tick.sv
module wdg_tick #(
    parameter int DIV = 1526
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [TW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == TW'(DIV - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        tick_o = (div_q == TW'(DIV - 1));
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // R5: ticks never come back to back when the divider is above one
            assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int               HALF_W     = 16,
    parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [HALF_W-1:0]     bus_wdata,
    output logic [HALF_W-1:0]     bus_rdata,
    input  logic [2*HALF_W-1:0]   count_i,
    input  logic                  int_flag_i,
    input  logic                  rst_flag_i,
    input  logic                  busy_i,
    output logic [2*HALF_W-1:0]   load_val_o,
    output logic [2*HALF_W-1:0]   pre_val_o,
    output logic                  ie_o,
    output logic                  ce_o,
    output logic                  re_o,
    output logic                  mask_o,
    output logic                  load_strobe_o,
    output logic                  clr_int_o,
    output logic                  clr_rst_o
);
    localparam int VW = 2 * HALF_W;

    logic              unlocked_q;
    logic [VW-1:0]     load_q;
    logic [VW-1:0]     pre_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              mask_q;
    logic              wr_en;
    logic              accept;

    always_comb begin
        wr_en  = bus_sel && bus_wr;
        accept = wr_en && unlocked_q && (bus_addr != OFS_LOCK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
            load_q     <= '0;
            pre_q      <= '0;
            ctrl_q     <= '0;
            mask_q     <= 1'b0;
        end else begin
            if (wr_en && bus_addr == OFS_LOCK) begin
                unlocked_q <= (bus_wdata == UNLOCK_KEY);
            end
            if (accept) begin
                unique case (bus_addr)
                    OFS_LDLO: load_q[HALF_W-1:0]  <= bus_wdata;
                    OFS_LDHI: load_q[VW-1:HALF_W] <= bus_wdata;
                    OFS_PRLO: pre_q[HALF_W-1:0]   <= bus_wdata;
                    OFS_PRHI: pre_q[VW-1:HALF_W]  <= bus_wdata;
                    OFS_CTRL: ctrl_q              <= bus_wdata[CTRL_W-1:0];
                    OFS_MASK: mask_q              <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        load_strobe_o = accept && (bus_addr == OFS_LDLO || bus_addr == OFS_LDHI ||
                                   bus_addr == OFS_PRLO || bus_addr == OFS_PRHI);
        clr_int_o     = accept && (bus_addr == OFS_ICLR) && bus_wdata[SB_INT];
        clr_rst_o     = accept && (bus_addr == OFS_ICLR) && bus_wdata[SB_RST];
        load_val_o    = load_q;
        pre_val_o     = pre_q;
        ie_o          = ctrl_q[CB_IE];
        ce_o          = ctrl_q[CB_CE];
        re_o          = ctrl_q[CB_RE];
        mask_o        = mask_q;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_LDLO:  bus_rdata = load_q[HALF_W-1:0];
            OFS_LDHI:  bus_rdata = load_q[VW-1:HALF_W];
            OFS_PRLO:  bus_rdata = pre_q[HALF_W-1:0];
            OFS_PRHI:  bus_rdata = pre_q[VW-1:HALF_W];
            OFS_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
            OFS_MASK:  bus_rdata[0] = mask_q;
            OFS_CNTLO: bus_rdata = count_i[HALF_W-1:0];
            OFS_CNTHI: bus_rdata = count_i[VW-1:HALF_W];
            OFS_RAW: begin
                bus_rdata[SB_INT]  = int_flag_i;
                bus_rdata[SB_RST]  = rst_flag_i;
                bus_rdata[SB_BUSY] = busy_i;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R2: a locked block keeps its control and start value through writes
    assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked_q && bus_addr != OFS_LOCK) |=> ($stable(ctrl_q) && $stable(load_q)));

    // R2: a locked write never begins a reload
    assert_locked_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked_q) |-> !load_strobe_o);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          load_strobe_i,
    input  logic [CW-1:0] load_val_i,
    input  logic [CW-1:0] pre_val_i,
    input  logic          cnt_en_i,
    input  logic          clr_int_i,
    input  logic          clr_rst_i,
    output logic [CW-1:0] count_o,
    output logic          int_flag_o,
    output logic          rst_flag_o,
    output logic          busy_o
);
    localparam int XFER_TICKS = 3;
    localparam int XW = $clog2(XFER_TICKS + 1);

    wd_state_e     st_q, st_d;
    logic [XW-1:0] xfer_q;
    logic [CW-1:0] cnt_q;
    logic          int_q;
    logic          rst_q;
    logic          xfer_done;
    logic          dec;
    logic [CW-1:0] cnt_m1;
    logic          int_set;
    logic          rst_set;

    always_comb begin
        xfer_done = (st_q == WD_XFER) && tick_i && (xfer_q == XW'(XFER_TICKS - 1)) && !load_strobe_i;
        dec       = (st_q == WD_RUN) && cnt_en_i && tick_i && !load_strobe_i;
        cnt_m1    = cnt_q - 1'b1;
        int_set   = dec && (cnt_q != '0) && (cnt_m1 == pre_val_i);
        rst_set   = dec && (cnt_q <= CW'(1));
    end

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_HALT:  if (cnt_en_i) st_d = WD_RUN;
            WD_XFER:  if (xfer_done) st_d = cnt_en_i ? WD_RUN : WD_HALT;
            WD_RUN: begin
                if (!cnt_en_i)    st_d = WD_HALT;
                else if (rst_set) st_d = WD_FIRED;
            end
            WD_FIRED: if (!cnt_en_i) st_d = WD_HALT;
        endcase
        if (load_strobe_i) st_d = WD_XFER;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WD_HALT;
            xfer_q <= '0;
            cnt_q  <= '0;
            int_q  <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load_strobe_i) begin
                xfer_q <= '0;
            end else if (st_q == WD_XFER && tick_i) begin
                xfer_q <= xfer_q + 1'b1;
            end
            if (xfer_done) begin
                cnt_q <= load_val_i;
            end else if (dec && cnt_q != '0) begin
                cnt_q <= cnt_m1;
            end
            int_q <= int_set | (int_q & ~clr_int_i);
            rst_q <= rst_set | (rst_q & ~clr_rst_i);
        end
    end

    // outputs
    always_comb begin
        busy_o     = (st_q == WD_XFER);
        count_o    = cnt_q;
        int_flag_o = int_q;
        rst_flag_o = rst_q;
    end

    // R4: the busy flag falls exactly when the start value lands in the counter
    assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (count_o == load_val_i));

    // R5: each tick in the running state takes exactly one off the count
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && count_o != '0) |=> (count_o == CW'($past(count_o) - 1'b1)));

    // R6: the warning flag appears with the count at the threshold
    assert_pre_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag_o) |-> (count_o == pre_val_i));

    // R7: the expiry flag appears only with the count at zero
    assert_zero_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_flag_o) |-> (count_o == '0));

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
    import wdg_pkg::*;
#(
    parameter int                TICK_DIV   = 1526,
    parameter int                HALF_W     = 16,
    parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int CW = 2 * HALF_W;

    logic          tick;
    logic [CW-1:0] count;
    logic [CW-1:0] load_val;
    logic [CW-1:0] pre_val;
    logic          int_flag, rst_flag, busy;
    logic          ie, ce, re, mask;
    logic          load_strobe, clr_int, clr_rst;

    wdg_tick #(.DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    wdg_regs #(.HALF_W(HALF_W), .UNLOCK_KEY(UNLOCK_KEY)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .count_i       (count),
        .int_flag_i    (int_flag),
        .rst_flag_i    (rst_flag),
        .busy_i        (busy),
        .load_val_o    (load_val),
        .pre_val_o     (pre_val),
        .ie_o          (ie),
        .ce_o          (ce),
        .re_o          (re),
        .mask_o        (mask),
        .load_strobe_o (load_strobe),
        .clr_int_o     (clr_int),
        .clr_rst_o     (clr_rst)
    );

    wdg_core #(.CW(CW)) core_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .load_strobe_i (load_strobe),
        .load_val_i    (load_val),
        .pre_val_i     (pre_val),
        .cnt_en_i      (ce),
        .clr_int_i     (clr_int),
        .clr_rst_i     (clr_rst),
        .count_o       (count),
        .int_flag_o    (int_flag),
        .rst_flag_o    (rst_flag),
        .busy_o        (busy)
    );

    always_comb begin
        irq_o     = int_flag & ie & ~mask;
        rst_req_o = rst_flag & re;
    end

    // R8: a clear request on the warning flag leaves it low on the next cycle unless the same edge set it again
    assert_clear_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !(tick && ce)) |=> !int_flag);

endmodule

// File: tb/wdog_lockable_tb_top.sv
module wdog_lockable_tb_top;
    localparam int DIV = 4;
    localparam logic [5:0] A_LDLO = 6'h00, A_LDHI = 6'h04, A_CTRL = 6'h08, A_ICLR = 6'h0C,
                           A_RAW = 6'h10, A_MASK = 6'h14, A_CNLO = 6'h18, A_CNHI = 6'h1C,
                           A_LOCK = 6'h20, A_PRLO = 6'h2C, A_PRHI = 6'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdog_lockable #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    function automatic int busy_lo(); return 2 * DIV + 1; endfunction
    function automatic int busy_hi(); return 3 * DIV; endfunction
    function automatic int ev_lo(int steps); return (steps - 1) * DIV; endfunction
    function automatic int ev_hi(int steps); return steps * DIV + 3; endfunction
    function automatic bit exp_irq(bit flag, bit ie, bit msk); return flag & ie & ~msk; endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(string req, string what, int act, int lo, int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd32(logic [5:0] lo, logic [5:0] hi, output logic [31:0] v);
        logic [15:0] l, h;
        rd(lo, l);
        rd(hi, h);
        v = {h, l};
    endtask

    task automatic wait_busy(output int n);
        logic [15:0] s;
        n = 0;
        rd(A_RAW, s);
        while (s[4] && n < 100 * DIV) begin
            n++;
            @(negedge clk);
            rd(A_RAW, s);
        end
    endtask

    task automatic wait_flag(int bitpos, output int n);
        logic [15:0] s;
        n = 0;
        rd(A_RAW, s);
        while (!s[bitpos] && n < 200 * DIV) begin
            n++;
            @(negedge clk);
            rd(A_RAW, s);
        end
    endtask

    task automatic load_vals(logic [31:0] ld, logic [31:0] pr, string req);
        int n;
        wr(A_LDLO, ld[15:0]);
        wr(A_LDHI, ld[31:16]);
        wr(A_PRLO, pr[15:0]);
        wr(A_PRHI, pr[31:16]);
        wait_busy(n);
        chk_rng(req, "busy cycles", n, busy_lo(), busy_hi());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before the test ended");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [31:0] v, v2;
        int n;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d);  chk("R1", "ctrl", d, 0);
        rd(A_RAW, d);   chk("R1", "status", d, 0);
        rd(A_MASK, d);  chk("R1", "mask", d, 0);
        rd32(A_CNLO, A_CNHI, v); chk("R1", "count", v, 0);
        rd32(A_LDLO, A_LDHI, v); chk("R1", "start", v, 0);
        chk("R1", "irq_o", irq_o, 0);
        chk("R1", "rst_req_o", rst_req_o, 0);

        // R2 locked after reset
        wr(A_CTRL, 16'h000F);
        rd(A_CTRL, d);  chk("R2", "locked ctrl write", d, 0);
        wr(A_LDLO, 16'h0055);
        rd(A_RAW, d);   chk("R2", "locked write busy", d[4], 0);
        rd(A_LDLO, d);  chk("R2", "locked start write", d, 0);
        wr(A_LOCK, 16'hE551);

        // R9 bit 2 stored, no counting
        wr(A_CTRL, 16'h0004);
        rd(A_CTRL, d);  chk("R9", "ctrl bit2 readback", d, 4);

        // R3/R4 split values and reload
        load_vals(32'h0003_0010, 32'h0001_0002, "R4");
        rd32(A_CNLO, A_CNHI, v); chk("R4", "count after reload", v, 32'h0003_0010);
        rd(A_CNHI, d);  chk("R3", "count upper half", d, 16'h0003);
        rd(A_CNLO, d);  chk("R3", "count lower half", d, 16'h0010);
        rd(A_PRHI, d);  chk("R3", "threshold upper half", d, 16'h0001);
        rd(A_PRLO, d);  chk("R3", "threshold lower half", d, 16'h0002);
        repeat (3 * DIV) @(negedge clk);
        rd32(A_CNLO, A_CNHI, v); chk("R9", "bit2 alone leaves count", v, 32'h0003_0010);

        // R2 non-key value locks again
        wr(A_LOCK, 16'h1234);
        wr(A_LDHI, 16'h0000);
        rd(A_LDHI, d);  chk("R2", "relocked start write", d, 16'h0003);
        rd(A_RAW, d);   chk("R2", "relocked busy", d[4], 0);
        wr(A_CTRL, 16'h0000);
        rd(A_CTRL, d);  chk("R2", "relocked ctrl write", d, 4);
        wr(A_LOCK, 16'hE551);
        wr(A_CTRL, 16'h0000);

        // random runs: R5 R6 R7 R8 R9
        for (int it = 0; it < 12; it++) begin
            int L, P;
            bit ie, re, msk;
            L   = 8 + int'($urandom % 40);
            P   = 1 + int'($urandom % (L - 1));
            ie  = 1'($urandom);
            re  = 1'($urandom);
            msk = 1'($urandom);
            wr(A_MASK, {15'd0, msk});
            load_vals(32'(L), 32'(P), "R4");
            rd32(A_CNLO, A_CNHI, v); chk("R4", "random reload", v, L);
            wr(A_CTRL, {12'd0, re, 1'b0, 1'b1, ie});
            wait_flag(0, n);
            chk_rng("R5", "cycles to threshold", n, ev_lo(L - P), ev_hi(L - P));
            rd32(A_CNLO, A_CNHI, v); chk("R6", "count at warning", v, P);
            chk("R6", "irq_o", irq_o, exp_irq(1'b1, ie, msk));
            chk("R7", "rst_req_o before expiry", rst_req_o, 0);
            wait_flag(3, n);
            chk_rng("R5", "cycles to expiry", n, ev_lo(P), ev_hi(P));
            rd32(A_CNLO, A_CNHI, v); chk("R7", "count at expiry", v, 0);
            chk("R7", "rst_req_o", rst_req_o, re);
            repeat (2 * DIV) @(negedge clk);
            rd32(A_CNLO, A_CNHI, v); chk("R7", "count holds at zero", v, 0);
            wr(A_CTRL, 16'h0000);
            chk("R9", "irq_o after ctrl 0", irq_o, 0);
            chk("R9", "rst_req_o after ctrl 0", rst_req_o, 0);
            rd(A_RAW, d);  chk("R9", "flags kept after ctrl 0", d, 16'h0009);
            wr(A_ICLR, 16'h0001);
            rd(A_RAW, d);  chk("R8", "clear warning only", d, 16'h0008);
            wr(A_ICLR, 16'h0008);
            rd(A_RAW, d);  chk("R8", "clear expiry", d, 16'h0000);
        end

        // R7 zero threshold sets both flags together
        wr(A_MASK, 16'h0000);
        load_vals(32'd10, 32'd0, "R4");
        wr(A_CTRL, 16'h000B);
        wait_flag(3, n);
        rd(A_RAW, d);  chk("R7", "zero threshold flags", d, 16'h0009);
        chk("R7", "irq_o with zero threshold", irq_o, 1);
        chk("R7", "rst_req_o with zero threshold", rst_req_o, 1);
        wr(A_CTRL, 16'h0000);
        wr(A_ICLR, 16'h0009);
        rd(A_RAW, d);  chk("R8", "clear both", d, 0);

        // R4 keep-alive while running, R9 freeze
        load_vals(32'd30, 32'd3, "R4");
        wr(A_CTRL, 16'h0002);
        repeat (10 * DIV) @(negedge clk);
        rd32(A_CNLO, A_CNHI, v);
        chk_rng("R5", "count after ten ticks", int'(v), 19, 21);
        wr(A_LDLO, 16'd30);
        wait_busy(n);
        chk_rng("R4", "keep-alive busy cycles", n, busy_lo(), busy_hi());
        rd32(A_CNLO, A_CNHI, v); chk("R4", "keep-alive reload", v, 30);
        rd(A_RAW, d);  chk("R4", "no warning after keep-alive", d, 0);
        repeat (4 * DIV) @(negedge clk);
        wr(A_CTRL, 16'h0000);
        rd32(A_CNLO, A_CNHI, v);
        repeat (5 * DIV) @(negedge clk);
        rd32(A_CNLO, A_CNHI, v2);
        chk("R9", "count frozen after ctrl 0", v2, v);
        chk_rng("R5", "count moved while running", int'(v), 24, 27);

        summary();
        $finish;
    end
endmodule